// File: doc/BRIEF.md
# Timer Channel with Compare, Capture and PWM

This block is one channel of a general-purpose timer. The counter and its prescaler sit outside the channel and deliver the current count on `cnt_in`. A small register port reaches two registers. The control register holds a 2-bit mode field, a 2-bit edge/level field, an interrupt enable bit and a sticky event flag. The value register holds a match value or a captured count.

The mode and edge/level fields are decoded into one of six named states:
- `ST_OFF`: disabled.
- `ST_CAPT`: input capture.
- `ST_CMP`: output compare.
- `ST_PWM`: pulse-width modulation.
- `ST_PLS_HI`: single high pulse on a match.
- `ST_PLS_LO`: single low pulse on a match.

The only transition in the state register is "load on control write": every write to the control register moves the state to the decode of the new fields, and no other event changes it. A match is one cycle in which the count newly equals the value register. In the compare and pulse states a match drives the pin; in the PWM state the pin follows a comparison of the count against the value. In the capture state, edges on the synchronised capture input copy the count into the value register. Any match or capture sets the flag, and the flag drives the interrupt when the interrupt is enabled.

The PWM alignment is set by the shape of the shared counter. With a sawtooth counter the output is edge-aligned. With an up/down counter the same rule gives a center-aligned output.

Top module: `timer_chan`

## Requirements
- R1: Control register layout: bits[1:0] are the edge/level field (lvl), bits[3:2] the mode field, bit 4 the interrupt enable and bit 5 the flag. With mode 01 (`ST_CMP`), a match acts on the pin registered in the same cycle: lvl 00 leaves it unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1. The pin keeps its level when one compare configuration replaces another.
- R2: With mode 11 and lvl 01 (`ST_PLS_HI`), the pin idles at 0 and is 1 for exactly the one cycle after a match. With mode 11 and lvl 10 (`ST_PLS_LO`), the pin idles at 1 and is 0 for that one cycle. Mode 11 with lvl 00 or 11 decodes to `ST_OFF`.
- R3: With mode 00 and a nonzero lvl (`ST_CAPT`), lvl 01 captures on rising edges of `cap_in` only, 10 on falling edges only and 11 on both. On a capture the count is copied into the value register and the flag is set. Edges that are not selected change neither the value register nor the flag.
- R4: The value register is read with `rd_sel`=1 and written with `wr_sel`=1. Outside `ST_CAPT` it changes only on a write and holds the match value. In `ST_CAPT` it holds the last captured count.
- R5: In `ST_PWM` (mode 10), the pin is registered from the comparison count < value. lvl 10 gives high-true output, lvl 01 gives low-true output and lvl 00 holds the pin at 0. A sawtooth count 0..TOP gives an edge-aligned output that is asserted from count 0. An up/down count 0..TOP..1 gives a center-aligned output of 2*value-1 active cycles in each 2*TOP-cycle period.
- R6: In PWM, a value of 0 keeps the output permanently inactive. A value of TOP+1 (the full period) keeps it permanently active.
- R7: Writing 0 to both the mode field and the lvl field selects `ST_OFF`, in which the pin is 0 and no event sets the flag. A control read returns the written mode and lvl in the cycle after the write.
- R8: The flag is sticky. A control write with bit 5 set clears it. An event in the same cycle as such a write wins, and the flag stays set.
- R9: `irq` is high exactly when the flag is set and the interrupt enable bit is 1.
- R10: `cap_in` passes through two synchroniser flops before edge detection. A capture stores the count present two cycles after the cycle in which `cap_in` changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | W | Shared counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 value |
| wr_data | input | W | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 value |
| rd_data | output | W | Read data |
| cap_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Channel output pin |
| irq | output | 1 | Channel interrupt |

## Verification
Two functions can fall in the same cycle: a channel event setting the flag and a software write clearing it. The bench provokes this twice. It places a flag-clear control write in the very cycle in which a synchronised capture edge is taken, and again in the cycle in which the count reaches the compare value. Each time it judges from the read-back and from `irq` that the flag stayed set, and it then shows that a later clear with no event present does take effect.

// File: rtl/chan_pkg.sv
package chan_pkg;
    localparam int LVL_LSB   = 0;
    localparam int MODE_LSB  = 2;
    localparam int IE_BIT    = 4;
    localparam int FLAG_BIT  = 5;
    localparam int CTRL_BITS = 6;

    typedef enum logic [2:0] {
        ST_OFF, ST_CAPT, ST_CMP, ST_PWM, ST_PLS_HI, ST_PLS_LO
    } chan_st_e;

    function automatic chan_st_e st_decode(input logic [1:0] mode, input logic [1:0] lvl);
        chan_st_e s;
        case (mode)
            2'b00:   s = (lvl == 2'b00) ? ST_OFF : ST_CAPT;
            2'b01:   s = ST_CMP;
            2'b10:   s = ST_PWM;
            default: s = (lvl == 2'b01) ? ST_PLS_HI : ((lvl == 2'b10) ? ST_PLS_LO : ST_OFF);
        endcase
        return s;
    endfunction
endpackage

// File: rtl/chan_edge_det.sv
module chan_edge_det #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_in,
    input  logic [1:0] sel,
    output logic       evt
);
    logic [STAGES:0] sh_q;
    logic            rise;
    logic            fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], sig_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    assign evt  = (sel[0] & rise) | (sel[1] & fall);
endmodule

// File: rtl/chan_cmp.sv
module chan_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] val,
    output logic         hit,
    output logic         below
);
    logic eq_q;
    logic eq;

    assign eq    = (cnt == val);
    assign hit   = eq & ~eq_q;
    assign below = (cnt < val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end
endmodule

// File: rtl/chan_out_fsm.sv
module chan_out_fsm
    import chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_st_e   st,
    input  logic [1:0] lvl,
    input  logic       hit,
    input  logic       below,
    output logic       pin
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            unique case (st)
                ST_OFF, ST_CAPT: pin <= 1'b0;
                ST_CMP: begin
                    if (hit) begin
                        case (lvl)
                            2'b01:   pin <= ~pin;
                            2'b10:   pin <= 1'b0;
                            2'b11:   pin <= 1'b1;
                            default: pin <= pin;
                        endcase
                    end
                end
                ST_PWM: begin
                    if (lvl == 2'b10)      pin <= below;
                    else if (lvl == 2'b01) pin <= ~below;
                    else                   pin <= 1'b0;
                end
                ST_PLS_HI: pin <= hit;
                ST_PLS_LO: pin <= ~hit;
            endcase
        end
    end
endmodule

// File: rtl/timer_chan.sv
module timer_chan
    import chan_pkg::*;
#(
    parameter int W         = 16,
    parameter int SYNC_FLOPS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_in,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         cap_in,
    output logic         pin_out,
    output logic         irq
);
    localparam int PAD = W - CTRL_BITS;

    chan_st_e     st_q;
    logic [1:0]   mode_q;
    logic [1:0]   lvl_q;
    logic         ie_q;
    logic         flag_q;
    logic [W-1:0] val_q;
    logic         ctrl_wr;
    logic         val_wr;
    logic         hit;
    logic         below;
    logic         cap_evt;
    logic         cap_take;
    logic         cmp_evt;
    logic [1:0]   cap_sel;

    assign ctrl_wr = wr_en & ~wr_sel;
    assign val_wr  = wr_en & wr_sel;

    // state register: loaded only by a control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            mode_q <= 2'b00;
            lvl_q  <= 2'b00;
            ie_q   <= 1'b0;
        end else if (ctrl_wr) begin
            st_q   <= st_decode(wr_data[MODE_LSB+1:MODE_LSB], wr_data[LVL_LSB+1:LVL_LSB]);
            mode_q <= wr_data[MODE_LSB+1:MODE_LSB];
            lvl_q  <= wr_data[LVL_LSB+1:LVL_LSB];
            ie_q   <= wr_data[IE_BIT];
        end
    end

    assign cap_sel = (st_q == ST_CAPT) ? lvl_q : 2'b00;

    chan_edge_det #(.STAGES(SYNC_FLOPS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(cap_in), .sel(cap_sel), .evt(cap_evt)
    );

    chan_cmp #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_in), .val(val_q), .hit(hit), .below(below)
    );

    chan_out_fsm u_out (
        .clk(clk), .rst_n(rst_n), .st(st_q), .lvl(lvl_q), .hit(hit), .below(below), .pin(pin_out)
    );

    assign cap_take = (st_q == ST_CAPT) & cap_evt;
    assign cmp_evt  = hit & (st_q != ST_OFF) & (st_q != ST_CAPT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        val_q <= '0;
        else if (cap_take) val_q <= cnt_in;
        else if (val_wr)   val_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              flag_q <= 1'b0;
        else if (cap_take || cmp_evt)            flag_q <= 1'b1;
        else if (ctrl_wr && wr_data[FLAG_BIT])   flag_q <= 1'b0;
    end

    assign irq     = flag_q & ie_q;
    assign rd_data = rd_sel ? val_q : {{PAD{1'b0}}, flag_q, ie_q, mode_q, lvl_q};
endmodule

// File: rtl/chan_chk.sv
module chan_chk
    import chan_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input chan_st_e     st,
    input logic [1:0]   lvl,
    input logic         flag,
    input logic         hit,
    input logic         cap_evt,
    input logic         wr_en,
    input logic         wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] cnt_in,
    input logic [W-1:0] val,
    input logic         pin
);
    AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMP && lvl == 2'b11 && hit) |=> pin); // R1

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PLS_HI && $past(st) == ST_PLS_HI && pin && !wr_en) |=> !pin); // R2

    AST_CAPT_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPT && cap_evt) |=> (val == $past(cnt_in) && flag)); // R3

    AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_CAPT && !(wr_en && wr_sel)) |=> $stable(val)); // R4

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && !flag && !(wr_en && !wr_sel)) |=> !flag); // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && !wr_sel && wr_data[FLAG_BIT])) |=> flag); // R8
endmodule

bind timer_chan chan_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_q), .lvl(lvl_q), .flag(flag_q), .hit(hit),
    .cap_evt(cap_evt), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_in(cnt_in), .val(val_q), .pin(pin_out)
);

// File: tb/sim_timer_chan.sv
`timescale 1ns/1ps
module sim_timer_chan;
    localparam int W   = 8;
    localparam int TOP = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_in = '0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic         cap_in = 1'b0;
    logic         pin_out;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    timer_chan #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cap_in(cap_in),
        .pin_out(pin_out), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] ctl(input bit fc, input bit ie, input logic [1:0] mode, input logic [1:0] lvl);
        return {2'b00, fc, ie, mode, lvl};
    endfunction

    function automatic int seq(input bit center, input int i);
        if (!center || i <= TOP) return i;
        return 2 * TOP - i;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int v);
        @(negedge clk);
        cnt_in = v[W-1:0];
        wr_en  = 1'b0;
    endtask

    task automatic step_wr(input int v, input bit sel, input logic [W-1:0] d);
        @(negedge clk);
        cnt_in  = v[W-1:0];
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
    endtask

    task automatic rd(input bit sel, output int v);
        rd_sel = sel;
        #1;
        v = int'(rd_data);
    endtask

    task automatic period(input bit center);
        int p;
        p = center ? 2 * TOP : TOP + 1;
        for (int i = 0; i < p; i++) step(seq(center, i));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int ones;
        int p;
        int exp_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0);
        // reset state (R7, R9)
        rd(1'b0, v); chk("R7 reset ctrl", v, 0);
        rd(1'b1, v); chk("R4 reset value", v, 0);
        chk("R7 reset pin", pin_out, 0);
        chk("R9 reset irq", irq, 0);

        // PWM sweep: both alignments, both polarities, every duty (R5, R6)
        for (int c = 0; c < 2; c++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int d = 0; d <= TOP + 1; d++) begin
                    step_wr(0, 1'b1, d[W-1:0]);
                    step_wr(0, 1'b0, ctl(1'b0, 1'b0, 2'b10, pol ? 2'b01 : 2'b10));
                    period(c[0]);
                    p = c ? 2 * TOP : TOP + 1;
                    ones = 0;
                    for (int i = 0; i < p; i++) begin
                        step(seq(c[0], i));
                        ones += int'(pin_out);
                    end
                    if (c == 0) exp_hi = d;
                    else if (d == 0) exp_hi = 0;
                    else if (d > TOP) exp_hi = p;
                    else exp_hi = 2 * d - 1;
                    if (d == 0 || d == TOP + 1)
                        chk("R6 pwm duty extreme", ones, pol ? p - exp_hi : exp_hi);
                    else
                        chk("R5 pwm active count", ones, pol ? p - exp_hi : exp_hi);
                end
            end
        end
        // edge-aligned asserts at count 0 (R5)
        step_wr(0, 1'b1, 8'd3);
        step_wr(0, 1'b0, ctl(1'b0, 1'b0, 2'b10, 2'b10));
        period(1'b0);
        step(7); step(0); step(1);
        chk("R5 edge pwm asserted after zero", pin_out, 1);

        // disable and read-back (R7)
        step_wr(0, 1'b0, ctl(1'b1, 1'b0, 2'b00, 2'b00));
        step(0);
        rd(1'b0, v); chk("R7 disable readback", v, 0);
        period(1'b0);
        rd(1'b0, v); chk("R7 no flag when off", v, 0);
        chk("R7 pin low when off", pin_out, 0);

        // output compare actions, value 3 (R1)
        step_wr(0, 1'b1, 8'd3);
        step_wr(0, 1'b0, ctl(1'b1, 1'b0, 2'b01, 2'b11));
        period(1'b0);
        chk("R1 set on match", pin_out, 1);
        rd(1'b1, v); chk("R4 value holds match", v, 3);
        step_wr(0, 1'b0, ctl(1'b1, 1'b0, 2'b01, 2'b10));
        period(1'b0);
        chk("R1 clear on match", pin_out, 0);
        step_wr(0, 1'b0, ctl(1'b1, 1'b0, 2'b01, 2'b01));
        period(1'b0);
        chk("R1 toggle first", pin_out, 1);
        period(1'b0);
        chk("R1 toggle second", pin_out, 0);
        period(1'b0);
        chk("R1 toggle third", pin_out, 1);
        step_wr(0, 1'b0, ctl(1'b1, 1'b0, 2'b01, 2'b00));
        period(1'b0);
        chk("R1 no action keeps pin", pin_out, 1);
        rd(1'b0, v); chk("R8 flag set by match", (v >> 5) & 1, 1);
        // clear collides with a match (R8)
        step(0); step(1); step(2);
        step_wr(3, 1'b0, ctl(1'b1, 1'b1, 2'b01, 2'b00));
        step(4);
        rd(1'b0, v); chk("R8 match beats clear", (v >> 5) & 1, 1);
        chk("R9 irq with enable", irq, 1);
        step_wr(5, 1'b0, ctl(1'b1, 1'b1, 2'b01, 2'b00));
        step(6);
        rd(1'b0, v); chk("R8 clear without event", (v >> 5) & 1, 0);
        chk("R9 irq follows flag", irq, 0);

        // pulse modes (R2)
        for (int k = 0; k < 2; k++) begin
            step_wr(0, 1'b0, ctl(1'b1, 1'b0, 2'b11, k ? 2'b10 : 2'b01));
            period(1'b0);
            ones = 0;
            for (int i = 0; i <= TOP; i++) begin
                step(i);
                ones += int'(pin_out);
                if (i == 4) chk("R2 pulse after match", pin_out, k ? 0 : 1);
            end
            chk("R2 single pulse width", ones, k ? TOP : 1);
        end
        step_wr(0, 1'b0, ctl(1'b1, 1'b0, 2'b11, 2'b11));
        period(1'b0);
        rd(1'b0, v); chk("R2 mode 11 lvl 11 off no flag", (v >> 5) & 1, 0);

        // input capture, rising only, interrupt enabled (R3, R10, R8)
        step_wr(10, 1'b0, ctl(1'b1, 1'b1, 2'b00, 2'b01));
        step(20); cap_in = 1'b1;
        step(21);
        step_wr(22, 1'b0, ctl(1'b1, 1'b1, 2'b00, 2'b01));
        rd(1'b1, v); chk("R10 not yet captured", v, 3);
        step(23);
        rd(1'b1, v); chk("R10 captured count two cycles later", v, 22);
        rd(1'b0, v); chk("R8 capture beats clear", (v >> 5) & 1, 1);
        chk("R9 irq on capture", irq, 1);
        step_wr(24, 1'b0, ctl(1'b1, 1'b1, 2'b00, 2'b01));
        step(30); cap_in = 1'b0;
        for (int i = 31; i < 37; i++) step(i);
        rd(1'b1, v); chk("R3 rising mode ignores fall value", v, 22);
        rd(1'b0, v); chk("R3 rising mode ignores fall flag", (v >> 5) & 1, 0);
        // falling only
        step_wr(38, 1'b0, ctl(1'b1, 1'b0, 2'b00, 2'b10));
        step(40); cap_in = 1'b1;
        for (int i = 41; i < 46; i++) step(i);
        rd(1'b1, v); chk("R3 falling mode ignores rise", v, 22);
        step(50); cap_in = 1'b0;
        step(51); step(52); step(53);
        rd(1'b1, v); chk("R3 falling capture", v, 52);
        // both edges
        step_wr(54, 1'b0, ctl(1'b1, 1'b0, 2'b00, 2'b11));
        step(60); cap_in = 1'b1;
        step(61); step(62); step(63);
        rd(1'b1, v); chk("R3 both edges rise", v, 62);
        step(70); cap_in = 1'b0;
        step(71); step(72); step(73);
        rd(1'b1, v); chk("R3 both edges fall", v, 72);
        chk("R3 pin low in capture", pin_out, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule